// File: doc/BRIEF.md
# Ring Oscillator Count-Window Meter

This block measures how fast the silicon is by counting the cycles of an on-die ring oscillator during a fixed stretch of reference-clock time. A one-cycle start pulse raises an oscillator enable that gates the first NAND stage of the ring. The block then opens a counting window of 64 reference cycles. The window edges cross into the oscillator domain through a two-flop synchroniser. There a 9-bit counter, built from three chained 3-bit stages, counts oscillator edges. The counter saturates at 511 and flags the overflow instead of wrapping. When the window closes, the oscillator side flips a toggle. The reference side synchronises that toggle and only then captures the frozen count. After capture it drops the enable, so the ring burns no power between measurements.

The captured count is compared against a programmable nominal count and tolerance. A count above the band is fast, a count below it is slow, and a count inside it is typical. The signed distance from nominal, clamped to 8 bits, is delivered as the result word over a valid/ready output. The valid signal rises together with done. While valid is high and ready is low, the result, class and overflow flag hold still. A ready cycle consumes the word and drops valid. A new start or power-down withdraws the word without waiting for ready. Done stays high until the next start or power-down. Power-down aborts any measurement and stops the oscillator. The nominal and tolerance inputs must be held steady during a measurement.

Top module: `ro_window_meter`

## Requirements
- R1: A start pulse seen while no measurement is running raises osc_en on the next clock edge and opens a counting window of exactly 64 reference cycles. osc_en stays high until the count has been captured. A start while a measurement is running is ignored.
- R2: The edge counter is 9 bits wide and made of three cascaded 3-bit stages, each advancing when the stage below it wraps. The captured count equals the number of oscillator rising edges inside the synchronised window, within two counts.
- R3: The counter stops at 511. The overflow output is 1 only when an oscillator edge arrived inside the window while the count was already 511; otherwise it is 0.
- R4: With d = count − nominal and tol the tolerance, the class output is 2'b01 (fast) when d > tol, 2'b10 (slow) when d < −tol, and 2'b00 (typical) otherwise. The value 2'b11 never appears.
- R5: The result is d as 8-bit two's complement, clamped to the range −128 to +127.
- R6: Done rises when a measurement's count is captured. It then holds until a start is accepted or power-down is asserted.
- R7: While pwr_down is high, the next edge forces osc_en, done and res_valid low, and start is ignored.
- R8: res_valid rises together with done. While res_valid is high and res_ready is low, with no start or power-down, res_valid, result, class and overflow stay unchanged. A cycle with res_valid and res_ready both high clears res_valid on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_clk | input | 1 | Ring oscillator output, used as the counter clock |
| start | input | 1 | One-cycle request to begin a measurement |
| pwr_down | input | 1 | Abort and hold the oscillator off |
| nominal | input | 9 | Expected count for a typical die |
| tol | input | 8 | Half-width of the typical band in counts |
| res_ready | input | 1 | Consumer accepts the result word |
| osc_en | output | 1 | Enable for the oscillator's first NAND stage |
| done | output | 1 | Measurement complete, held |
| res_valid | output | 1 | Result word available |
| result | output | 8 | Clamped signed distance of count from nominal |
| cls | output | 2 | Class: 00 typical, 01 fast, 10 slow |
| overflow | output | 1 | Counter reached saturation during the window |

## Verification
Every cycle, the checker checks the following:
- the window lasts exactly 64 cycles and osc_en covers it;
- power-down silences the enable and both flags on the next edge;
- done and res_valid obey their hold rules;
- result and class stay frozen under back-pressure;
- the class agrees in sign with the result word.

The count itself depends on the oscillator period and on where the asynchronous window edges land. So only the bench's scenarios can show the counting accuracy, saturation and overflow, the clamping at both ends, and the class chosen against a given nominal and tolerance. Those scenarios are swept over directed corner periods and random ones.

// File: rtl/omw_pkg.sv
`timescale 1ns/1ps
package omw_pkg;

  typedef enum logic [1:0] {
    CLS_TYP  = 2'b00,
    CLS_FAST = 2'b01,
    CLS_SLOW = 2'b10
  } cls_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_WAIT,
    ST_FIN
  } st_e;

endpackage

// File: rtl/omw_cnt_stage.sv
`timescale 1ns/1ps
module omw_cnt_stage #(
  parameter int SB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          hold,
  output logic [SB-1:0] q,
  output logic          carry
);

  localparam logic [SB-1:0] QMAX = {SB{1'b1}};

  assign carry = adv && (q == QMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (adv && !hold) begin
      q <= q + 1'b1;
    end
  end

endmodule

// File: rtl/omw_osc_side.sv
`timescale 1ns/1ps
module omw_osc_side #(
  parameter int SB     = 3,
  parameter int NSTAGE = 3
) (
  input  logic                 osc_clk,
  input  logic                 osc_rst_n,
  input  logic                 win_ref,
  output logic [SB*NSTAGE-1:0] cnt,
  output logic                 ovf,
  output logic                 tog
);

  localparam int CNT_W = SB * NSTAGE;

  logic              win_s1, win_s2, win_s3;
  logic [NSTAGE:0]   adv;
  logic              sat;

  assign sat    = &cnt;
  assign adv[0] = win_s2;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    omw_cnt_stage #(.SB(SB)) u_stage (
      .clk   (osc_clk),
      .rst_n (osc_rst_n),
      .adv   (adv[g]),
      .hold  (sat),
      .q     (cnt[g*SB +: SB]),
      .carry (adv[g+1])
    );
  end

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      win_s1 <= 1'b0;
      win_s2 <= 1'b0;
      win_s3 <= 1'b0;
      ovf    <= 1'b0;
      tog    <= 1'b0;
    end else begin
      win_s1 <= win_ref;
      win_s2 <= win_s1;
      win_s3 <= win_s2;
      if (adv[NSTAGE]) ovf <= 1'b1;
      if (win_s3 && !win_s2) tog <= ~tog;
    end
  end

  logic unused_w;
  assign unused_w = ^{CNT_W[0]};

endmodule

// File: rtl/omw_classify.sv
`timescale 1ns/1ps
module omw_classify #(
  parameter int CNT_W = 9,
  parameter int TOL_W = 8,
  parameter int RES_W = 8
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] nominal,
  input  logic [TOL_W-1:0] tol,
  output logic [RES_W-1:0] res,
  output logic [1:0]       cls
);
  import omw_pkg::*;

  localparam int DW = ((CNT_W > TOL_W) ? CNT_W : TOL_W) + 2;
  localparam logic signed [DW-1:0] RMAX = DW'((1 << (RES_W-1)) - 1);
  localparam logic signed [DW-1:0] RMIN = -RMAX - 1;

  logic signed [DW-1:0] diff, tol_s;

  always_comb begin
    diff  = $signed(DW'(cnt)) - $signed(DW'(nominal));
    tol_s = $signed(DW'(tol));
    if (diff > RMAX)      res = RMAX[RES_W-1:0];
    else if (diff < RMIN) res = RMIN[RES_W-1:0];
    else                  res = diff[RES_W-1:0];
    if (diff > tol_s)       cls = CLS_FAST;
    else if (diff < -tol_s) cls = CLS_SLOW;
    else                    cls = CLS_TYP;
  end

endmodule

// File: rtl/omw_ref_ctrl.sv
`timescale 1ns/1ps
module omw_ref_ctrl #(
  parameter int DIV_BITS = 6,
  parameter int RES_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pwr_down,
  input  logic             tog_x,
  input  logic             ovf_x,
  input  logic [RES_W-1:0] res_c,
  input  logic [1:0]       cls_c,
  input  logic             res_ready,
  output logic             osc_en,
  output logic             win,
  output logic             done,
  output logic             res_valid,
  output logic [RES_W-1:0] result,
  output logic [1:0]       cls,
  output logic             overflow
);
  import omw_pkg::*;

  localparam logic [DIV_BITS-1:0] DIV_MAX = {DIV_BITS{1'b1}};

  st_e                 st, nxt;
  logic [DIV_BITS-1:0] div;
  logic                tog_s1, tog_s2, tog_seen;
  logic                chg, accept, capture;

  assign chg     = tog_s2 ^ tog_seen;
  assign accept  = ((st == ST_IDLE) || (st == ST_FIN)) && start && !pwr_down;
  assign capture = (st == ST_WAIT) && chg && !pwr_down;

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE, ST_FIN: if (start)          nxt = ST_OPEN;
      ST_OPEN:         if (div == DIV_MAX) nxt = ST_WAIT;
      ST_WAIT:         if (chg)            nxt = ST_FIN;
      default:                             nxt = ST_IDLE;
    endcase
    if (pwr_down) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      div       <= '0;
      osc_en    <= 1'b0;
      win       <= 1'b0;
      tog_s1    <= 1'b0;
      tog_s2    <= 1'b0;
      tog_seen  <= 1'b0;
      done      <= 1'b0;
      res_valid <= 1'b0;
      result    <= '0;
      cls       <= CLS_TYP;
      overflow  <= 1'b0;
    end else begin
      st     <= nxt;
      osc_en <= (nxt == ST_OPEN) || (nxt == ST_WAIT);
      win    <= (nxt == ST_OPEN);
      div    <= (st == ST_OPEN) ? div + 1'b1 : '0;

      if (!osc_en) begin
        tog_s1   <= 1'b0;
        tog_s2   <= 1'b0;
        tog_seen <= 1'b0;
      end else begin
        tog_s1   <= tog_x;
        tog_s2   <= tog_s1;
        tog_seen <= tog_s2;
      end

      if (capture) begin
        result   <= res_c;
        cls      <= cls_c;
        overflow <= ovf_x;
      end

      if (pwr_down || accept) done <= 1'b0;
      else if (capture)       done <= 1'b1;

      if (pwr_down || accept)          res_valid <= 1'b0;
      else if (capture)                res_valid <= 1'b1;
      else if (res_valid && res_ready) res_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/ro_window_meter.sv
`timescale 1ns/1ps
module ro_window_meter #(
  parameter int DIV_BITS = 6,
  parameter int SB       = 3,
  parameter int NSTAGE   = 3,
  parameter int TOL_W    = 8,
  parameter int RES_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 osc_clk,
  input  logic                 start,
  input  logic                 pwr_down,
  input  logic [SB*NSTAGE-1:0] nominal,
  input  logic [TOL_W-1:0]     tol,
  input  logic                 res_ready,
  output logic                 osc_en,
  output logic                 done,
  output logic                 res_valid,
  output logic [RES_W-1:0]     result,
  output logic [1:0]           cls,
  output logic                 overflow
);

  localparam int CNT_W = SB * NSTAGE;

  logic             osc_rst_n;
  logic             win_ref;
  logic [CNT_W-1:0] cnt_x;
  logic             ovf_x, tog_x;
  logic [RES_W-1:0] res_c;
  logic [1:0]       cls_c;

  assign osc_rst_n = rst_n & osc_en;

  omw_osc_side #(.SB(SB), .NSTAGE(NSTAGE)) u_osc (
    .osc_clk   (osc_clk),
    .osc_rst_n (osc_rst_n),
    .win_ref   (win_ref),
    .cnt       (cnt_x),
    .ovf       (ovf_x),
    .tog       (tog_x)
  );

  omw_classify #(.CNT_W(CNT_W), .TOL_W(TOL_W), .RES_W(RES_W)) u_cls (
    .cnt     (cnt_x),
    .nominal (nominal),
    .tol     (tol),
    .res     (res_c),
    .cls     (cls_c)
  );

  omw_ref_ctrl #(.DIV_BITS(DIV_BITS), .RES_W(RES_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pwr_down  (pwr_down),
    .tog_x     (tog_x),
    .ovf_x     (ovf_x),
    .res_c     (res_c),
    .cls_c     (cls_c),
    .res_ready (res_ready),
    .osc_en    (osc_en),
    .win       (win_ref),
    .done      (done),
    .res_valid (res_valid),
    .result    (result),
    .cls       (cls),
    .overflow  (overflow)
  );

endmodule

// File: rtl/ro_window_meter_chk.sv
`timescale 1ns/1ps
module ro_window_meter_chk #(
  parameter int DIV_BITS = 6,
  parameter int RES_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             pwr_down,
  input logic             res_ready,
  input logic             win,
  input logic             osc_en,
  input logic             done,
  input logic             res_valid,
  input logic [RES_W-1:0] result,
  input logic [1:0]       cls,
  input logic             overflow
);

  localparam int WLEN = 1 << DIV_BITS;

  logic [DIV_BITS:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run_len <= '0;
    else if (win) run_len <= run_len + 1'b1;
    else          run_len <= '0;
  end

  assert_win_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win) && !$past(pwr_down) |-> run_len == (DIV_BITS+1)'(WLEN));

  assert_win_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win |-> run_len < (DIV_BITS+1)'(WLEN));

  assert_en_covers_win_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win |-> osc_en);

  assert_cls_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cls != 2'b11);

  assert_fast_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && cls == 2'b01 |-> $signed(result) > 0);

  assert_slow_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && cls == 2'b10 |-> $signed(result) < 0);

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start && !pwr_down |=> done);

  assert_pd_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !osc_en && !done && !res_valid);

  assert_bp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready && !start && !pwr_down |=>
      res_valid && $stable(result) && $stable(cls) && $stable(overflow));

  assert_valid_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> done);

endmodule

bind ro_window_meter ro_window_meter_chk #(.DIV_BITS(DIV_BITS), .RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .pwr_down  (pwr_down),
  .res_ready (res_ready),
  .win       (win_ref),
  .osc_en    (osc_en),
  .done      (done),
  .res_valid (res_valid),
  .result    (result),
  .cls       (cls),
  .overflow  (overflow)
);

// File: tb/ro_window_meter_bench.sv
`timescale 1ns/1ps
module ro_window_meter_bench;

  logic       clk = 1'b0;
  logic       osc_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       pwr_down = 1'b0;
  logic       res_ready = 1'b0;
  logic [8:0] nominal = '0;
  logic [7:0] tol = '0;
  logic       osc_en, done, res_valid, overflow;
  logic [7:0] result;
  logic [1:0] cls;

  realtime osc_half = 0.5;
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always #(osc_half) osc_clk = ~osc_clk;

  ro_window_meter u_ro_window_meter (
    .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .start(start),
    .pwr_down(pwr_down), .nominal(nominal), .tol(tol),
    .res_ready(res_ready), .osc_en(osc_en), .done(done),
    .res_valid(res_valid), .result(result), .cls(cls), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clamp8(input int v);
    if (v > 127)  return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int cls_of(input int d, input int t);
    if (d > t)  return 1;
    if (d < -t) return 2;
    return 0;
  endfunction

  function automatic int sat9(input int v);
    return (v > 511) ? 511 : v;
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output int en_cyc, output bit got);
    en_cyc = 1;
    got = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
      if (osc_en) en_cyc++;
    end
  endtask

  task automatic measure(input int target, input int nom, input int t, input string tag);
    int en_cyc, lo, hi, rs, clo, chi;
    bit got;
    osc_half = 128.0 / target;
    nominal  = 9'(nom);
    tol      = 8'(t);
    pulse_start();
    wait_done(en_cyc, got);
    chk(got, {tag, " R6 done"}, int'(got), 1);
    chk(res_valid == 1'b1, {tag, " R8 valid with done"}, int'(res_valid), 1);
    chk(en_cyc >= 65 && en_cyc <= 76, {tag, " R1 enable length"}, en_cyc, 68);
    lo = sat9(target - 2);
    hi = sat9(target + 2);
    rs = int'($signed(result));
    chk(rs >= clamp8(lo - nom) && rs <= clamp8(hi - nom), {tag, " R2/R5 result"},
        rs, clamp8(target - nom));
    clo = cls_of(lo - nom, t);
    chi = cls_of(hi - nom, t);
    if (clo == chi) chk(int'(cls) == clo, {tag, " R4 class"}, int'(cls), clo);
    else if (rs > -128 && rs < 127)
      chk(int'(cls) == cls_of(rs, t), {tag, " R4 class vs result"}, int'(cls), cls_of(rs, t));
    if (target <= 509) chk(overflow == 1'b0, {tag, " R3 no overflow"}, int'(overflow), 0);
    if (target >= 515) chk(overflow == 1'b1, {tag, " R3 overflow"}, int'(overflow), 1);
  endtask

  task automatic ack();
    @(negedge clk) res_ready = 1'b1;
    @(negedge clk) res_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int en_cyc, tgt, nom, t;
    bit got;
    logic [7:0] r_hold;
    logic [1:0] c_hold;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(osc_en == 1'b0, "reset R7 osc_en", int'(osc_en), 0);
    chk(done == 1'b0, "reset R6 done", int'(done), 0);
    chk(res_valid == 1'b0, "reset R8 res_valid", int'(res_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    measure(250, 250, 10, "typical");
    ack();
    measure(400, 300, 5, "fast");
    ack();
    measure(100, 400, 20, "slow clamp");
    ack();
    measure(640, 300, 4, "saturate");
    ack();
    measure(505, 500, 30, "near full");

    // R8 back-pressure: word held while res_ready low
    r_hold = result;
    c_hold = cls;
    repeat (5) @(negedge clk);
    chk(res_valid == 1'b1, "R8 valid held", int'(res_valid), 1);
    chk(result == r_hold && cls == c_hold, "R8 word stable", int'(result), int'(r_hold));
    ack();
    chk(res_valid == 1'b0, "R8 cleared by ready", int'(res_valid), 0);
    chk(done == 1'b1, "R6 done held after ack", int'(done), 1);
    pulse_start();
    chk(done == 1'b0, "R6 cleared by start", int'(done), 1'b0);
    wait_done(en_cyc, got);
    ack();

    // R1: start during a running measurement is ignored
    osc_half = 128.0 / 300;
    pulse_start();
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done(en_cyc, got);
    en_cyc += 21;
    chk(got && en_cyc <= 76, "R1 restart ignored", en_cyc, 68);
    ack();

    // R7: power-down mid-window
    pulse_start();
    repeat (30) @(negedge clk);
    pwr_down = 1'b1;
    start    = 1'b1;
    @(negedge clk);
    chk(osc_en == 1'b0, "R7 osc_en off", int'(osc_en), 0);
    chk(done == 1'b0 && res_valid == 1'b0, "R7 flags off", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(osc_en == 1'b0, "R7 start ignored", int'(osc_en), 0);
    pwr_down = 1'b0;
    start    = 1'b0;
    repeat (120) @(negedge clk);
    chk(done == 1'b0 && osc_en == 1'b0, "R7 no measurement after abort",
        int'(done), 0);

    for (int k = 0; k < 12; k++) begin
      tgt = int'($urandom_range(480, 100));
      nom = tgt + int'($urandom_range(120, 0)) - 60;
      t   = int'($urandom_range(30, 0));
      measure(tgt, nom, t, $sformatf("random%0d", k));
      ack();
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule